// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel that raises a periodic or one-shot interrupt. Software loads a 16-bit fixed count and a control word through a small synchronous register bus. The control word picks one of several tick-enable inputs as the counting source and enables auto-reload, load-on-write and the interrupt output. Each tick on the selected source moves the running count one step towards zero. A tick that arrives while the count is at zero is an expiry. An expiry sets a sticky interrupt flag and, with reload enabled, restarts the count from the fixed value. The interrupt period is therefore the fixed count plus one ticks. For a source of 32000 ticks per second and a wanted rate F, the count to program is 32000/F - 1.

The control register sits behind four word addresses. One replaces its value, and the other three set, clear or toggle the bits named in the written mask, so software can change one bit without a read-modify-write. The interrupt is acknowledged by writing the flag bit to the clear address. The interrupt output is a level and stays high while the flag and its enable are both set. The bus, the tick inputs and the interrupt line are plain control signals with no handshake. A write completes in the cycle it is presented, and read data is a combinational function of the address.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the control word, the fixed count and the running count are all zero and `irq_o` is low.
- R2: Word offsets 0x00, 0x04, 0x08 and 0x0C all read the control word, and offset 0x10 reads the fixed count in bits 15:0 with the running count in bits 31:16. Offsets 0x14 to 0x1C read zero. Control bits are: flag 15, interrupt enable 14, load-on-write 7, reload 6, source select 3:0. All other control bits read zero.
- R3: A write to 0x00 replaces the control bits covered by the byte enables. Writes to 0x04, 0x08 and 0x0C respectively OR, AND-NOT and XOR the enabled mask into the control word.
- R4: A write to 0x10 updates only the fixed-count bytes whose enables are set. The upper half of that register ignores writes.
- R5: When load-on-write is set, a write to 0x10 that touches the fixed count copies the new fixed value into the running count on the same clock edge. When it is clear, the running count is unchanged.
- R6: A select value s from 1 to 15 counts on `tick_src[s-1]`, so the 32 kHz source value 8 uses `tick_src[7]`. Ticks on unselected inputs have no effect, and select 0 freezes the running count.
- R7: With reload set, a selected tick decrements a nonzero running count. A tick at zero sets the flag and reloads the fixed count, so the flag sets once every fixed+1 ticks.
- R8: With reload clear, the first tick at zero sets the flag once. The count then stays at zero and further ticks set nothing until the count is loaded again.
- R9: `irq_o` is high exactly while the flag and the interrupt enable are both set. The flag stays set whether or not the enable is set.
- R10: Writing bit 15 to the clear address drops the flag. If an expiry occurs in the same cycle, the expiry wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the 0x20 window |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_src | input | 15 | One tick-enable pulse per clock source |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check four things. An expiry always leaves the flag set and an acknowledgement without an expiry clears it. A reload lands exactly on the fixed value. Without a load or reload the running count never rises, and it holds still when the select is zero or a one-shot count has reached zero. Only the bench scenarios can show the end-to-end behaviour: the fixed+1 period, the routing of each select value to the right tick input, the byte-enable merging and read-back layout, the alias arithmetic, and the one-shot flag firing exactly once.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  // word index = byte offset >> 2
  localparam logic [2:0] WI_CTRL  = 3'd0;
  localparam logic [2:0] WI_SET   = 3'd1;
  localparam logic [2:0] WI_CLR   = 3'd2;
  localparam logic [2:0] WI_TOG   = 3'd3;
  localparam logic [2:0] WI_COUNT = 3'd4;

  localparam int B_FLAG = 15;
  localparam int B_IEN  = 14;
  localparam int B_UPD  = 7;
  localparam int B_RLD  = 6;
  localparam int SEL_LO = 0;

  localparam logic [DATA_W-1:0] CTRL_IMPL = 32'h0000_C0CF;

  localparam int FIX_LO = 0;
  localparam int RUN_LO = 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } ctrl_op_e;
endpackage

// File: rtl/itmr_ctrl_reg.sv
module itmr_ctrl_reg
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ctrl_op_e          op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] bits_in;
  logic [DATA_W-1:0] ctrl_nxt;

  assign bits_in = wdata & wmask;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_en) begin
      unique case (op)
        OP_WRITE: ctrl_nxt = (ctrl_q & ~wmask) | bits_in;
        OP_SET:   ctrl_nxt = ctrl_q | bits_in;
        OP_CLR:   ctrl_nxt = ctrl_q & ~bits_in;
        OP_TOG:   ctrl_nxt = ctrl_q ^ bits_in;
        default:  ctrl_nxt = ctrl_q;
      endcase
    end
    ctrl_nxt = ctrl_nxt & CTRL_IMPL;
    // a hardware expiry overrides any software clear in the same cycle
    if (expire) ctrl_nxt[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/itmr_fixed_reg.sv
module itmr_fixed_reg #(
  parameter int CNT_W = 16,
  localparam int NB   = (CNT_W + 7) / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NB-1:0]    be,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] fix_q,
  output logic [CNT_W-1:0] fix_nxt
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int LO = b * 8;
    localparam int HI = ((b * 8 + 8) > CNT_W) ? (CNT_W - 1) : (b * 8 + 7);
    logic [HI-LO:0] q;
    logic           hit;

    assign hit = wr_en & be[b];

    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata[HI:LO];
    end

    assign fix_q[HI:LO]   = q;
    assign fix_nxt[HI:LO] = hit ? wdata[HI:LO] : q;
  end
endmodule

// File: rtl/itmr_tick_sel.sv
module itmr_tick_sel #(
  parameter int SEL_W  = 4,
  localparam int NSRC  = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  tick_src,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = tick_src[i] & (sel == SEL_W'(i + 1));
  end

  // select value 0 matches no source, which freezes the counter
  assign tick = |hit;
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] fix_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic spent_q;
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && !load && at_zero && (reload_en || !spent_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      spent_q <= 1'b1;
    end else if (load) begin
      cnt_q   <= load_val;
      spent_q <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        spent_q <= 1'b1;
        if (reload_en) cnt_q <= fix_val;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4,
  localparam int NSRC  = (1 << SEL_W) - 1,
  localparam int NB    = (CNT_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   tick_src,
  output logic              irq_o
);
  logic [2:0]        word;
  logic              wr;
  logic              ctrl_wr;
  logic              cnt_wr;
  ctrl_op_e          op;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  fix_cnt;
  logic [CNT_W-1:0]  fix_nxt;
  logic [CNT_W-1:0]  run_cnt;
  logic              tick;
  logic              load;
  logic              expire;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr      = bus_sel & bus_wr;
  assign ctrl_wr = wr && (word <= WI_TOG);
  assign cnt_wr  = wr && (word == WI_COUNT);
  assign op      = ctrl_op_e'(word[1:0]);

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{bus_be[b]}};
  end

  itmr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .op     (op),
    .wdata  (bus_wdata),
    .wmask  (wmask),
    .expire (expire),
    .ctrl_q (ctrl_q)
  );

  itmr_fixed_reg #(.CNT_W(CNT_W)) u_fixed (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_wr),
    .be      (bus_be[NB-1:0]),
    .wdata   (bus_wdata[FIX_LO +: CNT_W]),
    .fix_q   (fix_cnt),
    .fix_nxt (fix_nxt)
  );

  itmr_tick_sel #(.SEL_W(SEL_W)) u_sel (
    .sel      (ctrl_q[SEL_LO +: SEL_W]),
    .tick_src (tick_src),
    .tick     (tick)
  );

  assign load = cnt_wr && (|bus_be[NB-1:0]) && ctrl_q[B_UPD];

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reload_en (ctrl_q[B_RLD]),
    .load      (load),
    .load_val  (fix_nxt),
    .fix_val   (fix_cnt),
    .cnt_q     (run_cnt),
    .expire    (expire)
  );

  always_comb begin
    bus_rdata = '0;
    if (word <= WI_TOG) begin
      bus_rdata = ctrl_q;
    end else if (word == WI_COUNT) begin
      bus_rdata[FIX_LO +: CNT_W] = fix_cnt;
      bus_rdata[RUN_LO +: CNT_W] = run_cnt;
    end
  end

  assign irq_o = ctrl_q[B_FLAG] & ctrl_q[B_IEN];
endmodule

// File: rtl/interval_timer_chan_chk.sv
module interval_timer_chan_chk
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  run_cnt,
  input logic [CNT_W-1:0]  fix_cnt,
  input logic              load,
  input logic              expire
);
  logic ack;
  assign ack = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == WI_CLR)
               && bus_be[1] && bus_wdata[B_FLAG];

  assert_expire_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl_q[B_FLAG]);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !ctrl_q[B_FLAG]);

  assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q[B_RLD] && !load) |=> (run_cnt == $past(fix_cnt)));

  assert_never_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire) |=> (run_cnt <= $past(run_cnt)));

  assert_sel_zero_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[3:0] == 4'd0) && !load) |=> $stable(run_cnt));

  assert_oneshot_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_RLD] && (run_cnt == '0) && !load) |=> (run_cnt == '0));
endmodule

bind interval_timer_chan interval_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .ctrl_q    (ctrl_q),
  .run_cnt   (run_cnt),
  .fix_cnt   (fix_cnt),
  .load      (load),
  .expire    (expire)
);

// File: tb/interval_timer_chan_test.sv
module interval_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] tick_src = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [14:0] SRC32K = 15'h0080;  // select 8 -> tick_src[7]

  always #10 clk = ~clk;

  interval_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_src(tick_src), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_tick(logic [4:0] a, logic [31:0] d, logic [3:0] be, logic [14:0] t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    tick_src = t;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; tick_src = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    wr_tick(a, d, be, '0);
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(logic [14:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = '0;
    end
  endtask

  task automatic chk_reg(string tag, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic chk_run(string tag, logic [15:0] exp);
    logic [31:0] d;
    rd(5'h10, d);
    check(tag, {16'h0, d[31:16]}, {16'h0, exp});
  endtask

  task automatic t_reset();
    chk_reg("R1 ctrl", 5'h00, 32'h0);
    chk_reg("R1 count", 5'h10, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_aliases();
    wr(5'h00, 32'h0000_00C3);
    chk_reg("R3 direct", 5'h00, 32'h0000_00C3);
    wr(5'h04, 32'h0000_4000);
    chk_reg("R3 set", 5'h04, 32'h0000_40C3);
    wr(5'h08, 32'h0000_0040);
    chk_reg("R3 clear", 5'h08, 32'h0000_4083);
    wr(5'h0C, 32'h0000_0081);
    chk_reg("R3 toggle", 5'h0C, 32'h0000_4002);
    wr(5'h00, 32'h0000_00FF, 4'b0001);
    chk_reg("R3 byte-enable", 5'h00, 32'h0000_40CF);
    wr(5'h00, 32'hFFFF_FFFF);
    chk_reg("R2 unimplemented bits", 5'h00, 32'h0000_C0CF);
    wr(5'h00, 32'h0);
    chk_reg("R2 empty offset", 5'h14, 32'h0);
  endtask

  task automatic t_count_bytes();
    wr(5'h10, 32'h0000_1234, 4'b0011);
    chk_reg("R4 half write", 5'h10, 32'h0000_1234);
    wr(5'h10, 32'hABCD_5678, 4'b1100);
    chk_reg("R4 upper half ignored", 5'h10, 32'h0000_1234);
    wr(5'h10, 32'h0000_00FF, 4'b0001);
    chk_reg("R4 low byte only", 5'h10, 32'h0000_12FF);
  endtask

  task automatic t_update();
    wr(5'h04, 32'h0000_0080);
    wr(5'h10, 32'h0000_0005, 4'b0011);
    chk_reg("R5 load on write", 5'h10, 32'h0005_0005);
  endtask

  task automatic t_periodic();
    wr(5'h00, 32'h0000_40C8);
    wr(5'h10, 32'h0000_0003, 4'b0011);
    chk_run("R5 loaded", 16'd3);
    for (int k = 1; k <= 3; k++) begin
      ticks(SRC32K, 1);
      chk_run("R7 decrement", 16'(3 - k));
      check("R7 no early irq", {31'h0, irq_o}, 32'h0);
    end
    ticks(SRC32K, 1);
    check("R7 irq after fixed+1", {31'h0, irq_o}, 32'h1);
    chk_run("R7 reloaded", 16'd3);
    chk_reg("R2 flag bit 15", 5'h00, 32'h0000_C0C8);
    wr(5'h08, 32'h0000_8000);
    check("R10 ack", {31'h0, irq_o}, 32'h0);
    chk_reg("R10 ack ctrl", 5'h00, 32'h0000_40C8);
    ticks(SRC32K, 3);
    check("R7 second period early", {31'h0, irq_o}, 32'h0);
    ticks(SRC32K, 1);
    check("R7 second period", {31'h0, irq_o}, 32'h1);
    wr(5'h08, 32'h0000_8000);
  endtask

  task automatic t_sources();
    chk_run("R6 start", 16'd3);
    ticks(15'h7F7F, 3);
    chk_run("R6 other sources ignored", 16'd3);
    wr(5'h00, 32'h0000_40C1);
    ticks(15'h0001, 1);
    chk_run("R6 select 1 uses input 0", 16'd2);
    wr(5'h08, 32'h0000_000F);
    ticks(15'h7FFF, 2);
    chk_run("R6 select 0 frozen", 16'd2);
    check("R6 no irq frozen", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_oneshot();
    wr(5'h00, 32'h0000_4088);
    wr(5'h10, 32'h0000_0002, 4'b0011);
    ticks(SRC32K, 2);
    chk_run("R8 at zero", 16'd0);
    check("R8 not yet", {31'h0, irq_o}, 32'h0);
    ticks(SRC32K, 1);
    check("R8 fires", {31'h0, irq_o}, 32'h1);
    chk_run("R8 stays zero", 16'd0);
    wr(5'h08, 32'h0000_8000);
    ticks(SRC32K, 3);
    check("R8 fires once", {31'h0, irq_o}, 32'h0);
    chk_run("R8 halted", 16'd0);
  endtask

  task automatic t_irq_enable();
    wr(5'h00, 32'h0000_00C8);
    wr(5'h10, 32'h0000_0001, 4'b0011);
    ticks(SRC32K, 2);
    check("R9 masked", {31'h0, irq_o}, 32'h0);
    chk_reg("R9 flag kept", 5'h00, 32'h0000_80C8);
    wr(5'h04, 32'h0000_4000);
    check("R9 enable raises", {31'h0, irq_o}, 32'h1);
    wr(5'h08, 32'h0000_C000);
    check("R9 cleared", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_collision();
    wr(5'h00, 32'h0000_40C8);
    wr(5'h10, 32'h0000_0000, 4'b0011);
    ticks(SRC32K, 1);
    check("R10 setup", {31'h0, irq_o}, 32'h1);
    wr_tick(5'h08, 32'h0000_8000, 4'hF, SRC32K);
    check("R10 expiry beats clear", {31'h0, irq_o}, 32'h1);
    wr(5'h08, 32'h0000_8000);
    check("R10 later clear", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aliases();
    t_count_bytes();
    t_update();
    t_periodic();
    t_sources();
    t_oneshot();
    t_irq_enable();
    t_collision();
    summary();
  end
endmodule